// File: doc/BRIEF.md
# Go-back-N speculative link sender

This block drives one direction of a point-to-point on-chip network link that uses speculative flow control. A flit taken from the upstream valid/ready interface goes onto the link with a request strobe in the next cycle, before the far end has said whether it kept it. Every flit that has been sent but not yet acknowledged stays in a local retransmission buffer. Because all storage and recovery logic sits here, the repeater stages on the link can be plain registers, and the only cost of those stages is a fixed round-trip delay.

Each flit carries a tag made of a sequence number and an epoch bit, and the receiver echoes that tag on the return path with either an acknowledgement or a rejection. An acknowledgement is cumulative: it frees the named flit and every older one. A rejection rewinds the sender to the named flit. The sender then sends it again, followed by every later buffered flit in the original order, and flips its epoch bit so that answers to flits sent before the rewind can be recognised and dropped. Upstream is held off while the buffer is full or while a replay is in progress.

A register-only link pipeline module with a configurable stage count is provided for building the link on both the forward and the return side.

Top module: `gbn_tx`

## Requirements
- R1: After reset, in_ready is 1 and out_req is 0.
- R2: A flit accepted (in_valid and in_ready high at a clock edge) appears on out_flit with out_req high in the following cycle. out_tag bits [SEQ_W-1:0] hold its sequence number and bit SEQ_W holds the current epoch. Sequence numbers start at 0 and step by one, modulo 2^SEQ_W, for each new flit.
- R3: At most DEPTH flits are outstanding (accepted and not yet acknowledged), and in_ready is 0 whenever DEPTH flits are outstanding.
- R4: A response with rsp_nack 0 whose epoch bit matches and whose sequence number names a sent, unacknowledged flit frees that flit and every older one.
- R5: A matching rejection (rsp_nack 1) drops in_ready in the next cycle. Two cycles after the rejection is presented, out_req is 1 and out_tag holds the rejected sequence number with the epoch bit inverted. The rejected flit and every later flit are then sent again in their original order.
- R6: A response whose epoch bit differs from the current epoch, or whose sequence number lies outside the sent and unacknowledged range, is ignored: it neither rewinds the sender nor drops in_ready.
- R7: Over a link of LINK_STAGES register stages in each direction, with random rejections, the receiver takes in exactly the accepted flits in acceptance order, with no gap and no duplicate.
- R8: Once a replay has resent every buffered flit and the buffer has drained, in_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream flit present |
| in_ready | output | 1 | Sender takes the upstream flit at this edge |
| in_flit | input | FLIT_W | Upstream flit payload |
| out_req | output | 1 | Link request strobe, flit on out_flit is valid |
| out_flit | output | FLIT_W | Flit payload towards the link |
| out_tag | output | SEQ_W+1 | {epoch, sequence number} of the flit on the link |
| rsp_valid | input | 1 | Response from the link return path is present |
| rsp_nack | input | 1 | 1 = rejection, 0 = acknowledgement |
| rsp_tag | input | SEQ_W+1 | Tag echoed from the flit being answered |

## Verification
The assertions assume that the far end answers each flit at most once, echoes the tag it received, and answers the flits of one epoch in the order they were sent. They also assume that rejections are only ever issued for the flit the receiver expected next, so that a live rejection always names the oldest outstanding flit. The bench receiver model keeps within this: it acknowledges or randomly rejects only the flit whose sequence number it expects, and it rejects every other arriving flit. Those other flits are all from a stale epoch, which also exercises the drop path continuously. The link stages are FIFO registers, so order on the return path is preserved by construction of the stimulus.

// File: rtl/gbn_pkg.sv
// Shared types for the go-back-N link sender.
package gbn_pkg;

    // Source of the flit loaded into the link output register this cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_NEW    = 2'd1,
        SRC_REPLAY = 2'd2
    } tx_src_e;

endpackage

// File: rtl/gbn_store.sv
// Retransmission storage: DEPTH flits, one write port, one combinational
// read port. Assumes DEPTH is a power of two so indices wrap naturally.
module gbn_store #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [FLIT_W-1:0] rd_data
);

    logic [FLIT_W-1:0] mem [DEPTH];

    // Capture a newly accepted flit into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the flit at the replay pointer.
    always_comb begin
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/gbn_ctrl.sv
// Window control for the go-back-N sender. Holds three sequence pointers:
// base (oldest unacknowledged), nxt (next to put on the link) and tail
// (next free slot), plus the epoch bit and the replay flag.
// Assumes DEPTH = 2^(SEQ_W-1), so the window never aliases the tag space,
// and that responses within one epoch arrive in send order.
module gbn_ctrl
    import gbn_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQ_W = $clog2(DEPTH) + 1,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             rsp_valid,
    input  logic             rsp_nack,
    input  logic [SEQ_W:0]   rsp_tag,
    output tx_src_e          src,
    output logic [SEQ_W-1:0] tx_seq,
    output logic             epoch,
    output logic             replay,
    output logic [SEQ_W-1:0] occ,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    localparam logic [SEQ_W-1:0] DEPTH_V = SEQ_W'(DEPTH);
    localparam logic [SEQ_W-1:0] ONE_V   = SEQ_W'(1);

    logic [SEQ_W-1:0] base, nxt, tail;
    logic [SEQ_W-1:0] sent_cnt, rsp_seq, rsp_off, nxt_inc;
    logic             rsp_ep, in_win, rsp_live, accept;

    // Occupancy, window membership and upstream handshake.
    always_comb begin
        occ      = tail - base;
        sent_cnt = nxt - base;
        rsp_seq  = rsp_tag[SEQ_W-1:0];
        rsp_ep   = rsp_tag[SEQ_W];
        rsp_off  = rsp_seq - base;
        in_win   = (rsp_off < sent_cnt);
        rsp_live = rsp_valid && (rsp_ep == epoch) && in_win;
        in_ready = !replay && (occ != DEPTH_V);
        accept   = in_valid && in_ready;
        nxt_inc  = nxt + ONE_V;
    end

    // Choose what goes on the link and where the store is addressed.
    always_comb begin
        if (replay) begin
            src = SRC_REPLAY;
        end else if (accept) begin
            src = SRC_NEW;
        end else begin
            src = SRC_NONE;
        end
        tx_seq = nxt;
        wr_en  = accept;
        wr_idx = tail[IDX_W-1:0];
        rd_idx = nxt[IDX_W-1:0];
    end

    // Advance pointers on accept, acknowledge, rewind and replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            nxt    <= '0;
            tail   <= '0;
            epoch  <= 1'b0;
            replay <= 1'b0;
        end else begin
            if (accept) begin
                tail <= tail + ONE_V;
            end
            if (rsp_live && !rsp_nack) begin
                base <= rsp_seq + ONE_V;
            end
            if (rsp_live && rsp_nack) begin
                base   <= rsp_seq;
                nxt    <= rsp_seq;
                replay <= 1'b1;
                epoch  <= ~epoch;
            end else if (replay) begin
                nxt <= nxt_inc;
                if (nxt_inc == tail) begin
                    replay <= 1'b0;
                end
            end else if (accept) begin
                nxt <= nxt_inc;
            end
        end
    end

endmodule

// File: rtl/gbn_link_pipe.sv
// Register-only link stage chain, STAGES deep (0 = wire). Used for both the
// forward flit path and the return response path; holds no flow control.
module gbn_link_pipe #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [STAGES];
            // Shift the bundle one stage per clock; reset clears the strobes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gbn_tx.sv
// Go-back-N speculative link sender. Accepts flits upstream, sends each one
// registered on the link with its {epoch, seq} tag, keeps it until a
// cumulative acknowledgement frees it, and on a rejection replays from the
// rejected flit. Assumes DEPTH is a power of two and SEQ_W is left at its
// derived default.
module gbn_tx #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              out_req,
    output logic [FLIT_W-1:0] out_flit,
    output logic [SEQ_W:0]    out_tag,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [SEQ_W:0]    rsp_tag
);
    import gbn_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    tx_src_e           src;
    logic [SEQ_W-1:0]  tx_seq, occ;
    logic              epoch, replay, wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [FLIT_W-1:0] rd_data;

    gbn_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .rsp_valid(rsp_valid),
        .rsp_nack (rsp_nack),
        .rsp_tag  (rsp_tag),
        .src      (src),
        .tx_seq   (tx_seq),
        .epoch    (epoch),
        .replay   (replay),
        .occ      (occ),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx)
    );

    gbn_store #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(in_flit),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    // Register the selected flit and its tag onto the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_req  <= 1'b0;
            out_flit <= '0;
            out_tag  <= '0;
        end else begin
            out_req <= (src != SRC_NONE);
            if (src != SRC_NONE) begin
                out_flit <= (src == SRC_REPLAY) ? rd_data : in_flit;
                out_tag  <= {epoch, tx_seq};
            end
        end
    end

endmodule

// File: rtl/gbn_tx_chk.sv
// Property checker for gbn_tx, attached by bind. Assumes responses follow
// the in-order, echo-the-tag convention described for the block.
module gbn_tx_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_req,
    input logic [SEQ_W:0]   out_tag,
    input logic             rsp_valid,
    input logic             rsp_ep,
    input logic [SEQ_W-1:0] occ,
    input logic             replay,
    input logic             epoch
);

    localparam logic [SEQ_W-1:0] DEPTH_V = SEQ_W'(DEPTH);

    // Parameter sanity: buffer must be a power of two of at least two.
    initial begin
        a_cfg_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0);
    end

    // R3: occupancy never exceeds the buffer.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);

    // R3: a full buffer holds upstream off.
    a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == DEPTH_V) |-> !in_ready);

    // R5: no new flit is taken while replaying.
    a_r5_replay_stall: assert property (@(posedge clk) disable iff (!rst_n)
        replay |-> !in_ready);

    // R2: back-to-back sends within one epoch carry consecutive numbers.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req) && (out_tag[SEQ_W] == $past(out_tag[SEQ_W])))
        |-> (out_tag[SEQ_W-1:0] == SEQ_W'($past(out_tag[SEQ_W-1:0]) + 1'b1)));

    // R6: a response from a stale epoch never triggers a rewind.
    a_r6_stale_no_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_ep != epoch)) |=> (epoch == $past(epoch)));

endmodule

bind gbn_tx gbn_tx_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_req  (out_req),
    .out_tag  (out_tag),
    .rsp_valid(rsp_valid),
    .rsp_ep   (rsp_tag[SEQ_W]),
    .occ      (occ),
    .replay   (replay),
    .epoch    (epoch)
);

// File: tb/gbn_tx_bench.sv
module gbn_tx_bench;

    localparam int FLIT_W = 16;
    localparam int DEPTH  = 8;
    localparam int SEQ_W  = 4;
    localparam int TAG_W  = SEQ_W + 1;
    localparam int STAGES = 4;
    localparam int FW     = 1 + TAG_W + FLIT_W;
    localparam int RW     = 3 + TAG_W;
    localparam int N_RAND = 500;
    localparam int N_SAT  = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              in_valid = 1'b0, in_ready;
    logic [FLIT_W-1:0] in_flit = '0;
    logic              out_req, rsp_valid, rsp_nack;
    logic [FLIT_W-1:0] out_flit;
    logic [SEQ_W:0]    out_tag, rsp_tag;
    logic [FW-1:0]     fwd_q;
    logic [RW-1:0]     ret_d, ret_q;
    logic              rsp_real;

    gbn_tx #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_gbn_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .out_req(out_req), .out_flit(out_flit), .out_tag(out_tag),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_tag(rsp_tag)
    );

    gbn_link_pipe #(.W(FW), .STAGES(STAGES)) u_fwd (
        .clk(clk), .rst_n(rst_n), .d({out_req, out_tag, out_flit}), .q(fwd_q));

    gbn_link_pipe #(.W(RW), .STAGES(STAGES)) u_ret (
        .clk(clk), .rst_n(rst_n), .d(ret_d), .q(ret_q));

    assign {rsp_valid, rsp_nack, rsp_real, rsp_tag} = ret_q;

    int tests = 0, fails = 0, cyc = 0;
    bit wd_hit = 0, nack_en = 1, drive_en = 0, drive_all = 0;
    int acc_cnt = 0, ack_cnt = 0, rx_cnt = 0, target = 0, full_seen = 0, stale_seen = 0;
    logic [FLIT_W-1:0] sent_q [0:1023];
    logic [SEQ_W-1:0]  rx_exp = '0;
    logic              exp_ep = 1'b0;
    int stall_cd = 0, replay_cd = 0, new_cd = 0, stale_cd = 0;
    logic [SEQ_W-1:0]  nack_seq, new_seq;
    logic              new_ep;
    logic [FLIT_W-1:0] new_flit, nack_flit;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: checks, receiver model, response bookkeeping, upstream drive.
    task automatic step();
        logic ep_now;
        logic [SEQ_W-1:0] fseq;
        bit rdy_before, stale_now;
        @(negedge clk);
        cyc++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            check(0, "R7 watchdog", cyc, 150000);
        end
        ep_now = exp_ep;
        if (stall_cd == 1) check(in_ready == 1'b0, "R5 stall after reject", int'(in_ready), 0);
        if (replay_cd == 1) begin
            check(out_req && out_tag == {exp_ep, nack_seq}, "R5 replay tag",
                  int'({out_req, out_tag}), int'({1'b1, exp_ep, nack_seq}));
            check(out_flit == nack_flit, "R5 replay flit", int'(out_flit), int'(nack_flit));
        end
        if (new_cd == 1)
            check(out_req && out_flit == new_flit && out_tag == {new_ep, new_seq},
                  "R2 new flit on link", int'({out_tag, out_flit}), int'({new_ep, new_seq, new_flit}));
        if (stale_cd == 1 && (acc_cnt - ack_cnt) < DEPTH)
            check(in_ready == 1'b1, "R6 stale response ignored", int'(in_ready), 1);
        if (stall_cd > 0) stall_cd--;
        if (replay_cd > 0) replay_cd--;
        if (new_cd > 0) new_cd--;
        if (stale_cd > 0) stale_cd--;
        if (acc_cnt - ack_cnt > DEPTH) check(0, "R3 outstanding bound", acc_cnt - ack_cnt, DEPTH);
        if (acc_cnt - ack_cnt == DEPTH) begin
            full_seen++;
            check(in_ready == 1'b0, "R3 full stall", int'(in_ready), 0);
        end
        rdy_before = in_ready;
        // receiver model at the far end of the forward link
        ret_d = '0;
        if (fwd_q[FW-1]) begin
            fseq = fwd_q[FLIT_W +: SEQ_W];
            if (fseq == rx_exp) begin
                if (nack_en && ($urandom % 8 == 0)) begin
                    ret_d = {1'b1, 1'b1, 1'b1, fwd_q[FLIT_W +: TAG_W]};
                end else begin
                    check(fwd_q[FLIT_W-1:0] == sent_q[rx_cnt], "R7 in-order delivery",
                          int'(fwd_q[FLIT_W-1:0]), int'(sent_q[rx_cnt]));
                    rx_cnt++;
                    rx_exp = rx_exp + 1'b1;
                    ret_d = {1'b1, 1'b0, 1'b1, fwd_q[FLIT_W +: TAG_W]};
                end
            end else begin
                ret_d = {1'b1, 1'b1, 1'b0, fwd_q[FLIT_W +: TAG_W]};
            end
        end
        // responses the sender consumes at the next edge
        stale_now = 0;
        if (rsp_valid && rsp_real) begin
            if (rsp_nack) begin
                stall_cd = 1;
                replay_cd = 2;
                exp_ep = ~exp_ep;
                nack_seq = rsp_tag[SEQ_W-1:0];
                nack_flit = sent_q[rx_cnt];
            end else begin
                ack_cnt++;
            end
        end else if (rsp_valid) begin
            stale_now = 1;
            stale_seen++;
        end
        // upstream drive
        in_valid = drive_en && (acc_cnt < target) && (drive_all || ($urandom % 4 != 0));
        in_flit = FLIT_W'($urandom);
        if (in_valid && in_ready) begin
            sent_q[acc_cnt] = in_flit;
            new_cd = 1;
            new_flit = in_flit;
            new_seq = SEQ_W'(acc_cnt);
            new_ep = ep_now;
            acc_cnt++;
        end
        if (stale_now && rdy_before && stall_cd == 0) stale_cd = 1;
    endtask

    task automatic drain();
        while (!wd_hit && (ack_cnt != acc_cnt || rx_cnt != acc_cnt)) step();
        drive_en = 0;
        repeat (4) step();
    endtask

    initial begin
        void'($urandom(32'd7));
        ret_d = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        check(out_req == 1'b0, "R1 reset out_req", int'(out_req), 0);

        // random traffic with random rejections
        target = N_RAND; drive_en = 1; nack_en = 1; drive_all = 0;
        while (!wd_hit && acc_cnt < target) step();
        drain();
        check(rx_cnt == N_RAND, "R7 all flits delivered", rx_cnt, N_RAND);
        check(ack_cnt == acc_cnt, "R4 every flit freed", ack_cnt, acc_cnt);
        check(in_ready == 1'b1, "R8 ready after replays", int'(in_ready), 1);
        check(stale_seen > 0, "R6 stale responses exercised", stale_seen, 1);

        // saturation: continuous input, no rejections, round trip above DEPTH
        target = N_RAND + N_SAT; drive_en = 1; nack_en = 0; drive_all = 1;
        while (!wd_hit && acc_cnt < target) step();
        drain();
        check(full_seen > 0, "R3 buffer reached full", full_seen, 1);
        check(rx_cnt == target, "R7 saturated delivery", rx_cnt, target);
        check(ack_cnt == acc_cnt, "R4 saturated frees", ack_cnt, acc_cnt);
        check(in_ready == 1'b1, "R8 ready after drain", int'(in_ready), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule